// File: doc/BRIEF.md
# PC-Relative Arithmetic and Load Unit

This unit carries out the program-counter-relative instruction group of a 64-bit processor. On a start strobe it takes the current program counter, a 21-bit immediate field and a destination register index. It finds the sub-operation from a prefix of the immediate's top bits. It then either forms an arithmetic result from the program counter at once, or issues one read on a simple memory port and formats the returned data.

The prefix is tested in three widths, longest first. A 5-bit match selects one of the two upper-immediate forms. Failing that, a 3-bit match selects the doubleword load. Failing that, a 2-bit match selects the add-immediate form or one of the two word loads. Each load form aligns the program counter and scales its offset in its own way. The result is returned with a write-back strobe and the destination index that was captured at the start. Any prefix that matches no form raises an illegal flag and writes nothing back.

Top module: `pcrel_unit`

## Requirements
- R1: After reset, `done_o`, `wb_en_o`, `illegal_o` and `rd_req_o` are all low.
- R2: Prefix `imm_i[20:16]` = 5'b11110 (upper add) gives result = pc + (sign-extended `imm_i[15:0]` << 16).
- R3: Prefix `imm_i[20:16]` = 5'b11111 (aligned upper add) gives the R2 sum with bits [15:0] cleared.
- R4: Prefix `imm_i[20:19]` = 2'b00 (add immediate) gives result = pc + (sign-extended `imm_i[18:0]` << 2).
- R5: Prefix `imm_i[20:19]` = 2'b01 (signed word load) reads from pc + (sign-extended `imm_i[18:0]` << 2) with `rd_size_o` = 0. The result is `rd_data_i[31:0]` sign-extended to 64 bits.
- R6: Prefix `imm_i[20:19]` = 2'b10 (unsigned word load) uses the R5 address and size. The result is `rd_data_i[31:0]` zero-extended, and `rd_data_i[63:32]` is ignored.
- R7: Prefix `imm_i[20:18]` = 3'b110 (doubleword load) reads from (pc with bits [2:0] cleared) + (sign-extended `imm_i[17:0]` << 3) with `rd_size_o` = 1. The result is `rd_data_i` unchanged.
- R8: A load holds `rd_req_o`, `rd_addr_o` and `rd_size_o` steady until `rd_valid_i` is sampled high. In the cycle after that, `done_o` and `wb_en_o` pulse for one cycle and `rd_req_o` drops.
- R9: Prefixes 5'b11100 and 5'b11101 match no form. They pulse `done_o` and `illegal_o` in the next cycle, with `wb_en_o` low and no read request.
- R10: `wb_idx_o` carries the `rs_i` value that was sampled with the accepted start.
- R11: A start while a read is outstanding is ignored. It produces no `done_o`, and the pending address and destination index stay unchanged.
- R12: Arithmetic forms complete in one cycle: `done_o` and `wb_en_o` pulse in the cycle after the start, with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one operation |
| pc_i | input | 64 | Current program counter |
| imm_i | input | 21 | Immediate field carrying the sub-operation prefix |
| rs_i | input | 5 | Destination register index |
| rd_req_o | output | 1 | Memory read request, held until data returns |
| rd_addr_o | output | 64 | Memory read byte address |
| rd_size_o | output | 1 | Read size: 0 = 32-bit word, 1 = 64-bit doubleword |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result value, valid with done_o |
| wb_en_o | output | 1 | Register write-back strobe |
| wb_idx_o | output | 5 | Register write-back index |
| illegal_o | output | 1 | Unrecognised prefix flag, pulses with done_o |

## Verification
The assertions check the handshake rules on every cycle:
- a pending request keeps its address and size until data is valid;
- a valid response is followed by a write-back completion;
- an illegal completion never writes back;
- an arithmetic start completes in the next cycle;
- the aligned form always clears its low half-word.

Only the bench scenarios can show that each prefix computes the right value. That covers the sign handling of the three offset widths, doubleword alignment of the program counter, sign versus zero extension of word data, and a start arriving mid-load leaving the pending destination untouched.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

  typedef enum logic [2:0] {
    OP_UPPER,
    OP_UPPER_AL,
    OP_ADDI,
    OP_LDW_S,
    OP_LDW_U,
    OP_LDD,
    OP_BAD
  } pcrel_op_e;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } pcrel_state_e;

  localparam logic [4:0] PFX5_UPPER    = 5'b11110;
  localparam logic [4:0] PFX5_UPPER_AL = 5'b11111;
  localparam logic [2:0] PFX3_LDD      = 3'b110;
  localparam logic [1:0] PFX2_ADDI     = 2'b00;
  localparam logic [1:0] PFX2_LDW_S    = 2'b01;
  localparam logic [1:0] PFX2_LDW_U    = 2'b10;

  function automatic logic op_is_load(input pcrel_op_e op);
    return (op == OP_LDW_S) || (op == OP_LDW_U) || (op == OP_LDD);
  endfunction

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
  import pcrel_pkg::*;
(
  input  logic [4:0] pfx_i,
  output pcrel_op_e  op_o
);
  // Longest prefix first: 5 bits, then 3, then 2.
  always_comb begin
    if (pfx_i == PFX5_UPPER)             op_o = OP_UPPER;
    else if (pfx_i == PFX5_UPPER_AL)     op_o = OP_UPPER_AL;
    else if (pfx_i[4:2] == PFX3_LDD)     op_o = OP_LDD;
    else if (pfx_i[4:3] == PFX2_ADDI)    op_o = OP_ADDI;
    else if (pfx_i[4:3] == PFX2_LDW_S)   op_o = OP_LDW_S;
    else if (pfx_i[4:3] == PFX2_LDW_U)   op_o = OP_LDW_U;
    else                                 op_o = OP_BAD;
  end
endmodule

// File: rtl/pcrel_addr.sv
module pcrel_addr
  import pcrel_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFF_W = 19
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  pcrel_op_e        op_i,
  output logic [XLEN-1:0]  arith_o,
  output logic [XLEN-1:0]  addr_o
);
  localparam int UPPER_W   = 16;
  localparam int DW_OFF_W  = OFF_W - 1;
  localparam int DW_ALIGN  = 3;

  logic [XLEN-1:0] upper_sum;
  logic [XLEN-1:0] word_sum;
  logic [XLEN-1:0] dw_sum;
  logic [XLEN-1:0] pc_dw;

  always_comb begin
    upper_sum = pc_i + (XLEN'($signed(off_i[UPPER_W-1:0])) << UPPER_W);
    word_sum  = pc_i + (XLEN'($signed(off_i)) << 2);
    pc_dw     = {pc_i[XLEN-1:DW_ALIGN], {DW_ALIGN{1'b0}}};
    dw_sum    = pc_dw + (XLEN'($signed(off_i[DW_OFF_W-1:0])) << DW_ALIGN);

    case (op_i)
      OP_UPPER:    arith_o = upper_sum;
      OP_UPPER_AL: arith_o = {upper_sum[XLEN-1:UPPER_W], {UPPER_W{1'b0}}};
      default:     arith_o = word_sum;
    endcase

    addr_o = (op_i == OP_LDD) ? dw_sum : word_sum;
  end
endmodule

// File: rtl/pcrel_fmt.sv
module pcrel_fmt
  import pcrel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  pcrel_op_e       op_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] res_o
);
  localparam int WORD_W = 32;

  always_comb begin
    case (op_i)
      OP_LDW_S: res_o = XLEN'($signed(data_i[WORD_W-1:0]));
      OP_LDW_U: res_o = XLEN'(data_i[WORD_W-1:0]);
      default:  res_o = data_i;
    endcase
  end
endmodule

// File: rtl/pcrel_unit.sv
module pcrel_unit
  import pcrel_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 21,
  parameter int IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [IDX_W-1:0]  rs_i,
  output logic              rd_req_o,
  output logic [XLEN-1:0]   rd_addr_o,
  output logic              rd_size_o,
  input  logic              rd_valid_i,
  input  logic [XLEN-1:0]   rd_data_i,
  output logic              done_o,
  output logic [XLEN-1:0]   result_o,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic              illegal_o
);
  localparam int PFX_W = 5;
  localparam int OFF_W = IMM_W - 2;

  pcrel_op_e       op;
  logic [XLEN-1:0] arith_res;
  logic [XLEN-1:0] ld_addr;
  logic [XLEN-1:0] fmt_res;

  pcrel_state_e    state_q, state_d;
  logic            req_q, req_d;
  logic            done_q, done_d;
  logic            wb_q, wb_d;
  logic            ill_q, ill_d;
  logic            cap_req, cap_res, cap_idx;
  logic [XLEN-1:0] res_d, res_q;
  logic [XLEN-1:0] addr_q;
  logic            size_q;
  pcrel_op_e       ld_op_q;
  logic [IDX_W-1:0] idx_q;

  pcrel_decode u_dec (
    .pfx_i (imm_i[IMM_W-1 -: PFX_W]),
    .op_o  (op)
  );

  pcrel_addr #(.XLEN(XLEN), .OFF_W(OFF_W)) u_addr (
    .pc_i    (pc_i),
    .off_i   (imm_i[OFF_W-1:0]),
    .op_i    (op),
    .arith_o (arith_res),
    .addr_o  (ld_addr)
  );

  pcrel_fmt #(.XLEN(XLEN)) u_fmt (
    .op_i   (ld_op_q),
    .data_i (rd_data_i),
    .res_o  (fmt_res)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    done_d  = 1'b0;
    wb_d    = 1'b0;
    ill_d   = 1'b0;
    cap_req = 1'b0;
    cap_res = 1'b0;
    cap_idx = 1'b0;
    res_d   = arith_res;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_idx = 1'b1;
          if (op == OP_BAD) begin
            done_d = 1'b1;
            ill_d  = 1'b1;
          end else if (op_is_load(op)) begin
            state_d = ST_WAIT;
            req_d   = 1'b1;
            cap_req = 1'b1;
          end else begin
            done_d  = 1'b1;
            wb_d    = 1'b1;
            cap_res = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (rd_valid_i) begin
          state_d = ST_IDLE;
          req_d   = 1'b0;
          done_d  = 1'b1;
          wb_d    = 1'b1;
          cap_res = 1'b1;
          res_d   = fmt_res;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      wb_q    <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
      wb_q    <= wb_d;
      ill_q   <= ill_d;
    end
  end

  // Data registers with explicit enables
  always_ff @(posedge clk_i) begin
    if (cap_req) begin
      addr_q  <= ld_addr;
      size_q  <= (op == OP_LDD);
      ld_op_q <= op;
    end
    if (cap_idx) begin
      idx_q <= rs_i;
    end
    if (cap_res) begin
      res_q <= res_d;
    end
  end

  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;
  assign rd_size_o = size_q;
  assign done_o    = done_q;
  assign wb_en_o   = wb_q;
  assign illegal_o = ill_q;
  assign result_o  = res_q;
  assign wb_idx_o  = idx_q;

endmodule

// File: rtl/pcrel_unit_chk.sv
module pcrel_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [4:0]      pfx_i,
  input logic            rd_req_o,
  input logic [XLEN-1:0] rd_addr_o,
  input logic            rd_size_o,
  input logic            rd_valid_i,
  input logic            done_o,
  input logic [15:0]     result_lo_o,
  input logic            wb_en_o,
  input logic            illegal_o
);

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !done_o && !rd_req_o && !wb_en_o && !illegal_o);

  // R9
  illegal_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && !wb_en_o);

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_size_o));

  // R8
  load_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_valid_i |=> done_o && wb_en_o && !rd_req_o);

  // R11
  busy_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> !done_o);

  // R12
  arith_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !rd_req_o && (pfx_i[4:1] == 4'b1111 || pfx_i[4:3] == 2'b00)
    |=> done_o && wb_en_o && !rd_req_o);

  // R3
  aligned_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !rd_req_o && pfx_i == 5'b11111 |=> result_lo_o == 16'h0000);

endmodule

bind pcrel_unit pcrel_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pfx_i       (imm_i[IMM_W-1 -: 5]),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_size_o   (rd_size_o),
  .rd_valid_i  (rd_valid_i),
  .done_o      (done_o),
  .result_lo_o (result_o[15:0]),
  .wb_en_o     (wb_en_o),
  .illegal_o   (illegal_o)
);

// File: tb/pcrel_unit_bench.sv
module pcrel_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] pc_i = '0;
  logic [20:0] imm_i = '0;
  logic [4:0]  rs_i = '0;
  logic        rd_req_o;
  logic [63:0] rd_addr_o;
  logic        rd_size_o;
  logic        rd_valid_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic        done_o;
  logic [63:0] result_o;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;
  logic        illegal_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk_i = ~clk_i;

  pcrel_unit u_pcrel_unit (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    longint m = longint'(1) << w;
    v = v & (m - 1);
    if (v >= (m >> 1)) v = v - m;
    return v;
  endfunction

  task automatic run_arith(input string tag, input [20:0] imm, input [4:0] rs,
                           input [63:0] pc, input [63:0] exp);
    @(negedge clk_i);
    start_i = 1; imm_i = imm; rs_i = rs; pc_i = pc;
    @(negedge clk_i);
    start_i = 0;
    chk({tag, " done"}, 64'(done_o), 64'd1);
    chk({tag, " wb"}, 64'(wb_en_o), 64'd1);
    chk({tag, " noreq"}, 64'(rd_req_o), 64'd0);
    chk({tag, " result"}, result_o, exp);
    chk({"R10 ", tag, " idx"}, 64'(wb_idx_o), 64'(rs));
    @(negedge clk_i);
    chk({tag, " pulse"}, 64'(done_o), 64'd0);
  endtask

  task automatic run_load(input string tag, input [20:0] imm, input [4:0] rs,
                          input [63:0] pc, input [63:0] data, input [63:0] exp_addr,
                          input exp_size, input [63:0] exp_res, input bit poke);
    @(negedge clk_i);
    start_i = 1; imm_i = imm; rs_i = rs; pc_i = pc;
    @(negedge clk_i);
    start_i = 0;
    chk({tag, " req"}, 64'(rd_req_o), 64'd1);
    chk({tag, " addr"}, rd_addr_o, exp_addr);
    chk({tag, " size"}, 64'(rd_size_o), 64'(exp_size));
    chk({tag, " nodone"}, 64'(done_o), 64'd0);
    if (poke) begin
      start_i = 1; imm_i = {5'b11110, 16'h0001}; rs_i = rs ^ 5'h1F; pc_i = 64'h10;
      @(negedge clk_i);
      start_i = 0;
      chk("R11 ignored start done", 64'(done_o), 64'd0);
      chk("R11 ignored start addr", rd_addr_o, exp_addr);
    end
    repeat (2) @(negedge clk_i);
    chk("R8 req held", 64'(rd_req_o), 64'd1);
    chk("R8 addr held", rd_addr_o, exp_addr);
    rd_valid_i = 1; rd_data_i = data;
    @(negedge clk_i);
    rd_valid_i = 0; rd_data_i = '0;
    chk("R8 done after valid", 64'(done_o), 64'd1);
    chk("R8 req dropped", 64'(rd_req_o), 64'd0);
    chk({tag, " wb"}, 64'(wb_en_o), 64'd1);
    chk({tag, " result"}, result_o, exp_res);
    chk({"R10 ", tag, " idx"}, 64'(wb_idx_o), 64'(rs));
    @(negedge clk_i);
    chk("R8 pulse", 64'(done_o), 64'd0);
  endtask

  task automatic run_illegal(input [4:0] pfx);
    @(negedge clk_i);
    start_i = 1; imm_i = {pfx, 16'h1234}; rs_i = 5'd9;
    @(negedge clk_i);
    start_i = 0;
    chk("R9 done", 64'(done_o), 64'd1);
    chk("R9 illegal", 64'(illegal_o), 64'd1);
    chk("R9 no wb", 64'(wb_en_o), 64'd0);
    chk("R9 no req", 64'(rd_req_o), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 req", 64'(rd_req_o), 64'd0);
    chk("R1 wb", 64'(wb_en_o), 64'd0);
    chk("R1 illegal", 64'(illegal_o), 64'd0);
  endtask

  initial begin
    longint pc;
    longint e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();

    pc = 64'h0000_1234_5678_9ABC;
    // R2 negative and positive upper immediate
    e = pc + sx(16'h8001, 16) * 65536;
    run_arith("R2 neg", {5'b11110, 16'h8001}, 5'd7, pc, e);
    e = pc + 64'h7FFF_0000;
    run_arith("R2 pos", {5'b11110, 16'h7FFF}, 5'd3, pc, e);
    // R3 aligned upper
    e = (pc + 64'h0123_0000) & ~64'hFFFF;
    run_arith("R3 aligned", {5'b11111, 16'h0123}, 5'd12, pc, e);
    // R12 and R4
    run_arith("R4 R12 minus", {2'b00, 19'h7FFFF}, 5'd1, pc, pc - 4);
    e = pc + 4 * 64'h3FFFF;
    run_arith("R4 plus", {2'b00, 19'h3FFFF}, 5'd30, pc, e);

    // R5 signed word load
    e = pc + sx(19'h40010, 19) * 4;
    run_load("R5 lw signed", {2'b01, 19'h40010}, 5'd5, pc, 64'h1357_2468_8000_1234,
             e, 1'b0, 64'hFFFF_FFFF_8000_1234, 1'b0);
    // R6 unsigned word load, upper data ignored, plus busy start (R11)
    e = pc + 4 * 64'd20;
    run_load("R6 lw unsigned", {2'b10, 19'd20}, 5'd17, pc, 64'hDEAD_BEEF_9000_0001,
             e, 1'b0, 64'h0000_0000_9000_0001, 1'b1);
    // R7 doubleword load with negative offset
    e = (pc & ~64'h7) + sx(18'h3FFFE, 18) * 8;
    run_load("R7 ld", {3'b110, 18'h3FFFE}, 5'd31, pc, 64'hA5A5_0F0F_F0F0_5A5A,
             e, 1'b1, 64'hA5A5_0F0F_F0F0_5A5A, 1'b0);

    // R9 unmatched prefixes
    run_illegal(5'b11100);
    run_illegal(5'b11101);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule